// File: doc/BRIEF.md
# Phase-Offset Clock Divider

This block turns a fast tick clock into a divided output clock whose first rising edge sits at a programmed phase. The fast clock runs at eight times the oscillator rate. Each tick therefore stands for one of eight equally spaced oscillator phases. One output period is `8 × N` ticks, where `N` is the divide value, and the duty cycle is 50%. The phase offset has two parts. The coarse part is a whole number of oscillator periods, worth eight ticks each. The fine part is an interpolator step code from 0 to 28 in units of 1/32 of a period, and it moves the output one tick per four code units.

Several instances share one synchronous reset. While reset is high, every instance captures its configuration and holds its output low. After reset is released, each instance waits out its own offset and then toggles on its own period. The phase of each channel relative to the others is therefore fixed by its configuration alone. Configuration inputs have no effect outside reset.

Top module: `phase_offset_divider`

## Requirements
- R1: On any clock edge at which `rst` is high, `clkOut` becomes low after that edge.
- R2: `divN`, `coarseDelay` and `stepCode` are captured only on edges at which `rst` is high. Changing them while `rst` is low leaves `clkOut` unchanged until the next reset.
- R3: Number the first edge with `rst` low as edge 0. The offset is `coarseDelay*8 + floor(stepCode/4)` ticks. `clkOut` stays low after every edge before the offset and becomes high after edge number offset.
- R4: Once running, `clkOut` stays high for exactly `4*N` consecutive edges.
- R5: Once running, `clkOut` stays low for exactly `4*N` consecutive edges between high phases, giving a period of `8*N` ticks.
- R6: Bits [1:0] of `stepCode` are ignored, so a code that is not a multiple of 4 acts as the next lower multiple of 4.
- R7: A `divN` value of 0 behaves exactly like a value of 1.
- R8: Two channels are released by the same reset, both with coarse delay 0, one with step 0 and one with step 16. Their rising edges are 4 ticks apart. This is 180° of the output period at N=1, 90° at N=2 and 45° at N=4.
- R9: Adding one to `coarseDelay` moves every output edge 8 ticks later, which is 360/N degrees of the output. Coarse values up to N cover a full output period for N up to 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock at eight times the oscillator rate |
| rst | input | 1 | Synchronous active-high reset that realigns all channels and captures configuration |
| divN | input | DIV_W (9) | Divide value N; 0 is treated as 1 |
| coarseDelay | input | DLY_W (9) | Whole oscillator periods of delay |
| stepCode | input | 5 | Fine interpolator step code in 1/32 period units, bits [1:0] ignored |
| clkOut | output | 1 | Divided, phase-offset output clock |

## Verification
`clkOut` is a register. The level that follows clock edge k, with edge 0 being the first edge at which reset is low, is a pure function of k, the captured N and the captured offset. The reference model in the bench advances its edge index on every rising edge. The bench compares the model's level with the output on the following falling edge, so each result is checked in the very cycle it is due. Reset takes effect on the first edge at which it is sampled, and the bench checks for a low output on the falling edge after that. Relative phase between two instances is taken from the edge index at which each output is first seen high after release.

// File: rtl/phase_div_pkg.sv
package phase_div_pkg;

  // Width of the interpolator step code (0..31, multiples of 4 used)
  localparam int STEP_CODE_W = 5;
  // Number of fine taps per oscillator period is 2**FINE_W
  localparam int FINE_W = 3;

  // Strobes issued by the sequencer to the counter datapath
  typedef struct packed {
    logic loadCfg;     // capture configuration, clear counters, force output low
    logic countDelay;  // advance the offset counter
    logic startPhase;  // offset elapsed: output high, period counter to 1
    logic runPhase;    // normal periodic operation
  } ctrlStrobe_t;

  typedef enum logic [0:0] {
    WAIT_S = 1'b0,
    RUN_S  = 1'b1
  } seqState_t;

endpackage

// File: rtl/phase_div_datapath.sv
module phase_div_datapath
  import phase_div_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int DLY_W = 9
) (
  input  logic                   clk,
  input  ctrlStrobe_t            strobe,
  input  logic [DIV_W-1:0]       divN,
  input  logic [DLY_W-1:0]       coarseDelay,
  input  logic [STEP_CODE_W-1:0] stepCode,
  output logic                   delayDone,
  output logic                   clkOut
);

  localparam int OFF_W = DLY_W + FINE_W;
  localparam int PH_W  = DIV_W + FINE_W;

  logic [DIV_W-1:0] divReg;
  logic [OFF_W-1:0] offsetReg;
  logic [OFF_W-1:0] delayCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic             outReg;

  logic [DIV_W-1:0] divNorm;
  logic [OFF_W-1:0] offsetNext;
  logic [PH_W-1:0]  halfPeriod;
  logic [PH_W-1:0]  lastPhase;
  logic             phaseWrap;

  // Divide value 0 is treated as 1
  assign divNorm = (divN == '0) ? DIV_W'(1) : divN;

  // Coarse periods in ticks plus the fine tap (step code rounded down to /4)
  assign offsetNext = {coarseDelay, {FINE_W{1'b0}}} + OFF_W'(stepCode >> 2);

  assign halfPeriod = {1'b0, divReg, 2'b00};
  assign lastPhase  = {divReg, 3'b000} - PH_W'(1);
  assign phaseWrap  = (phaseCnt == lastPhase);

  assign delayDone = (delayCnt == offsetReg);

  // Configuration capture
  always_ff @(posedge clk) begin
    if (strobe.loadCfg) begin
      divReg    <= divNorm;
      offsetReg <= offsetNext;
    end
  end

  // Offset counter
  always_ff @(posedge clk) begin
    if (strobe.loadCfg) begin
      delayCnt <= '0;
    end else if (strobe.countDelay) begin
      delayCnt <= delayCnt + OFF_W'(1);
    end
  end

  // Period counter and output register
  always_ff @(posedge clk) begin
    if (strobe.loadCfg) begin
      phaseCnt <= '0;
      outReg   <= 1'b0;
    end else if (strobe.startPhase) begin
      phaseCnt <= PH_W'(1);
      outReg   <= 1'b1;
    end else if (strobe.runPhase) begin
      phaseCnt <= phaseWrap ? '0 : phaseCnt + PH_W'(1);
      outReg   <= (phaseCnt < halfPeriod);
    end
  end

  assign clkOut = outReg;

endmodule

// File: rtl/phase_div_ctrl.sv
module phase_div_ctrl
  import phase_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        delayDone,
  output ctrlStrobe_t strobe
);

  seqState_t state;
  seqState_t stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (rst) begin
      strobe.loadCfg = 1'b1;
      stateNext      = WAIT_S;
    end else begin
      unique case (state)
        WAIT_S: begin
          if (delayDone) begin
            strobe.startPhase = 1'b1;
            stateNext         = RUN_S;
          end else begin
            strobe.countDelay = 1'b1;
          end
        end
        RUN_S: begin
          strobe.runPhase = 1'b1;
        end
        default: stateNext = WAIT_S;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state <= stateNext;
  end

endmodule

// File: rtl/phase_offset_divider.sv
module phase_offset_divider
  import phase_div_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int DLY_W = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIV_W-1:0]       divN,
  input  logic [DLY_W-1:0]       coarseDelay,
  input  logic [STEP_CODE_W-1:0] stepCode,
  output logic                   clkOut
);

  ctrlStrobe_t strobe;
  logic        delayDone;

  phase_div_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .delayDone (delayDone),
    .strobe    (strobe)
  );

  phase_div_datapath #(
    .DIV_W (DIV_W),
    .DLY_W (DLY_W)
  ) u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .divN        (divN),
    .coarseDelay (coarseDelay),
    .stepCode    (stepCode),
    .delayDone   (delayDone),
    .clkOut      (clkOut)
  );

endmodule

// File: rtl/phase_div_checker.sv
module phase_div_checker
  import phase_div_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int DLY_W = 9
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DIV_W-1:0]       divN,
  input logic [DLY_W-1:0]       coarseDelay,
  input logic [STEP_CODE_W-1:0] stepCode,
  input logic                   clkOut
);

  localparam int OFF_W = DLY_W + FINE_W;
  localparam int PH_W  = DIV_W + FINE_W;

  logic [DIV_W-1:0] nCap;
  logic [OFF_W-1:0] offCap;
  logic [31:0]      relCnt;
  logic [PH_W-1:0]  hiLen;
  logic [PH_W-1:0]  loLen;
  logic             seenHigh;

  always_ff @(posedge clk) begin
    if (rst) begin
      nCap     <= (divN == '0) ? DIV_W'(1) : divN;
      offCap   <= {coarseDelay, 3'b000} + OFF_W'(stepCode >> 2);
      relCnt   <= '0;
      hiLen    <= '0;
      loLen    <= '0;
      seenHigh <= 1'b0;
    end else begin
      relCnt   <= relCnt + 32'd1;
      hiLen    <= clkOut ? hiLen + PH_W'(1) : '0;
      loLen    <= clkOut ? '0 : loLen + PH_W'(1);
      seenHigh <= seenHigh | clkOut;
    end
  end

  // R1: output low on the first edge after reset
  assert_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !clkOut);

  // R3: first high level appears right after the programmed offset
  assert_first_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (!seenHigh && $rose(clkOut)) |-> (relCnt == 32'(offCap) + 32'd1));

  // R4: every complete high phase lasts 4*N ticks
  assert_high_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(clkOut) && !$past(rst)) |-> (hiLen == {1'b0, nCap, 2'b00}));

  // R5: every low phase between highs lasts 4*N ticks
  assert_low_len_R5: assert property (@(posedge clk) disable iff (rst)
    (seenHigh && $rose(clkOut)) |-> (loLen == {1'b0, nCap, 2'b00}));

endmodule

bind phase_offset_divider phase_div_checker #(
  .DIV_W (DIV_W),
  .DLY_W (DLY_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .divN        (divN),
  .coarseDelay (coarseDelay),
  .stepCode    (stepCode),
  .clkOut      (clkOut)
);

// File: tb/tb_phase_offset_divider.sv
module tb_phase_offset_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] divA = 9'd1, dlyA = 9'd0, divB = 9'd1, dlyB = 9'd0;
  logic [4:0] stepA = 5'd0, stepB = 5'd0;
  logic       outA, outB;

  int nChecks = 0;
  int nErrors = 0;
  string curTag = "R1";

  // behavioural reference state
  int relK = -1;
  int capNA = 1, capNB = 1, capOffA = 0, capOffB = 0;
  bit expA = 1'b0, expB = 1'b0;
  bit armed = 1'b0;
  bit prevA = 1'b0, prevB = 1'b0;
  int riseA = -1, riseB = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_offset_divider dut (
    .clk (clk), .rst (rst), .divN (divA), .coarseDelay (dlyA),
    .stepCode (stepA), .clkOut (outA)
  );

  phase_offset_divider dutB (
    .clk (clk), .rst (rst), .divN (divB), .coarseDelay (dlyB),
    .stepCode (stepB), .clkOut (outB)
  );

  function automatic bit modelLevel(int k, int n, int off);
    if (k < off) return 1'b0;
    return (((k - off) % (8 * n)) < (4 * n));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      capNA   = (divA == 0) ? 1 : int'(divA);
      capNB   = (divB == 0) ? 1 : int'(divB);
      capOffA = int'(dlyA) * 8 + int'(stepA) / 4;
      capOffB = int'(dlyB) * 8 + int'(stepB) / 4;
      relK    = -1;
      expA    = 1'b0;
      expB    = 1'b0;
      armed   = 1'b1;
    end else begin
      relK++;
      expA = modelLevel(relK, capNA, capOffA);
      expB = modelLevel(relK, capNB, capOffB);
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      check(outA == expA, curTag, "channel A level", int'(outA), int'(expA));
      check(outB == expB, curTag, "channel B level", int'(outB), int'(expB));
      if (!rst && outA && !prevA && riseA < 0) riseA = relK;
      if (!rst && outB && !prevB && riseB < 0) riseB = relK;
    end
    prevA = outA;
    prevB = outB;
  end

  task automatic runCase(int nA, int dA, int sA, int nB, int dB, int sB,
                         int cycles, string tag, int changeAt);
    @(negedge clk);
    divA = 9'(nA); dlyA = 9'(dA); stepA = 5'(sA);
    divB = 9'(nB); dlyB = 9'(dB); stepB = 5'(sB);
    rst = 1'b1;
    curTag = "R1";
    @(negedge clk);
    // R1: outputs low right after the first reset edge
    check(outA == 1'b0 && outB == 1'b0, "R1", "low during reset",
          int'(outA) + int'(outB), 0);
    @(negedge clk);
    riseA = -1; riseB = -1;
    curTag = tag;
    rst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i == changeAt) begin
        // R2: new values must not take effect while running
        divA = 9'd5; dlyA = 9'd7; stepA = 5'd13;
        divB = 9'd0; dlyB = 9'd2; stepB = 5'd30;
      end
    end
  endtask

  task automatic checkDegrees(int n, int expDeg, string req);
    int diff = riseB - riseA;
    check(riseA >= 0 && riseB >= 0, req, "both channels rose", riseB, riseA);
    check((diff * 360) / (8 * n) == expDeg, req, "phase degrees",
          (diff * 360) / (8 * n), expDeg);
  endtask

  initial begin
    // R8: step 0 vs step 16 at divide 1, 2, 4
    runCase(1, 0, 0, 1, 0, 16, 40, "R3 R4 R5 R8", -1);
    checkDegrees(1, 180, "R8");
    runCase(2, 0, 0, 2, 0, 16, 60, "R3 R4 R5 R8", -1);
    checkDegrees(2, 90, "R8");
    runCase(4, 0, 0, 4, 0, 16, 100, "R3 R4 R5 R8", -1);
    checkDegrees(4, 45, "R8");
    // R9: one coarse period apart at divide 3 -> 120 degrees
    runCase(3, 2, 0, 3, 3, 0, 120, "R3 R9", -1);
    checkDegrees(3, 120, "R9");
    check(riseA == 16, "R3", "coarse-only first rise", riseA, 16);
    // R7: divide 0 behaves like divide 1
    runCase(0, 1, 8, 1, 1, 8, 60, "R7", -1);
    check(riseA == riseB, "R7", "div0 vs div1 first rise", riseA, riseB);
    // R6: step 19 acts as 16
    runCase(6, 1, 16, 6, 1, 19, 120, "R6", -1);
    check(riseA == riseB && riseA == 12, "R6", "rounded step rise", riseB, 12);
    // R2: configuration changed mid-run has no effect
    runCase(2, 1, 4, 3, 0, 28, 150, "R2", 20);
    check(riseA == 9 && riseB == 7, "R2", "rises after change",
          riseA * 100 + riseB, 907);
    // R2: the changed values apply after the next reset
    runCase(5, 7, 13, 0, 2, 30, 150, "R2 R7", -1);
    check(riseA == 59 && riseB == 23, "R2", "rises with new config",
          riseA * 100 + riseB, 5923);
    // R9: full-range offset at divide 256
    runCase(256, 255, 28, 256, 0, 0, 6200, "R4 R5 R9", -1);
    check(riseA == 2047, "R9", "max offset rise", riseA, 2047);
    checkDegrees(256, -359, "R9");
    // R1: reset asserted mid-run forces output low
    runCase(1, 0, 0, 1, 0, 16, 6, "R1", -1);
    finishSim();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
    finishSim();
  end

endmodule